// File: doc/BRIEF.md
# Bit-Slip Word Aligner

The aligner takes one or more serial lanes, each qualified by a common bit-rate enable, and packs the captured bits into parallel words. The word width is set by a parameter. Link training logic elsewhere decides when a lane is misframed and asks for a slip. Each slip moves that lane's word boundary by exactly one serial bit. A slip works by discarding one serial bit at the next word boundary, so every later word is drawn from a window that is offset by one bit. After as many slips as the word width, the lane is back at its original framing. On that wrap the lane raises a one-cycle roll-over flag.

A per-lane aligner reset puts the lane back at zero slip offset. It does this by discarding however many bits are still missing to complete a full word of slip. It acts at any time, whether or not a slip is still pending, and it does not touch the global reset. One parameter selects the slip control. With one shared request, every lane slips together. With one request per lane, each lane slips alone.

The serial side carries no ready signal and the word side carries only a valid strobe. The block cannot be back-pressured. A disabled bit slot is skipped and costs nothing. The consumer must take each word in the cycle its strobe is high.

Top module: `bitslip_aligner`

## Requirements
- R1: Each lane outputs one FACTOR-bit word per FACTOR captured bits. The first captured bit is the word MSB. The word is presented together with a one-cycle valid strobe. After reset, the first word holds the first FACTOR bits sent.
- R2: A cycle with the bit-rate enable low captures nothing and does not disturb the framing.
- R3: An accepted slip request (a rising edge of the lane's slip input) discards exactly one serial bit at the next word boundary. For a repeating word W sent MSB first, a lane with n slips outputs W rotated left by n mod FACTOR.
- R4: While a slip is in progress, further requests are ignored. A slip is in progress from its acceptance until the first word at the new framing appears. Holding the slip input high counts as one request.
- R5: When the lane's cumulative slip count wraps from FACTOR-1 back to 0, the lane's roll-over output is high for exactly one cycle. That cycle coincides with the first word strobe at the restored framing. Other slips raise no roll-over.
- R6: A pulse on a lane's aligner reset returns that lane to zero offset and clears its slip count without a roll-over. It may be applied at any time, including while a slip is pending.
- R7: With SHARED=1, the single slip input slips every lane. With SHARED=0, a slip on one lane leaves the framing of the other lanes unchanged.
- R8: While rst_n is low, all word strobes, words and roll-over outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_i | input | CHANNELS | One serial bit per lane |
| ser_vld_i | input | 1 | Bit-rate enable shared by all lanes |
| slip_i | input | SHARED ? 1 : CHANNELS | Slip requests (rising-edge sensitive) |
| align_rst_i | input | CHANNELS | Per-lane aligner reset |
| word_o | output | CHANNELS*FACTOR | Realigned words, lane c at bits c*FACTOR upward |
| word_vld_o | output | CHANNELS | Per-lane word strobe |
| roll_o | output | CHANNELS | Per-lane roll-over pulse |

## Verification
The assertions check several rules on every cycle. A roll-over only ever appears with a word strobe, only when the slip count is back at zero, and never in two cycles in a row. A request that arrives while a slip is in progress does not change the slip count. An aligner reset always leaves a zero count. A discarded bit never advances the framing counter. Only the bench scenarios can show the rotation value of each word after each number of slips, that the wrap lands after exactly FACTOR slips, that an aligner reset restores the unrotated word, and how shared and independent slip control differ across lanes.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  // counter width able to hold values 0..n-1
  function automatic int unsigned idx_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/bsa_lane.sv
module bsa_lane #(
  parameter int unsigned FACTOR = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_i,
  input  logic              bit_vld_i,
  input  logic              drop_i,
  output logic              at_bnd_o,
  output logic [FACTOR-1:0] word_o,
  output logic              stb_o
);
  localparam int unsigned CW = bsa_pkg::idx_w(FACTOR);

  logic [CW-1:0]     cnt;
  logic [FACTOR-1:0] sr;
  logic              cap;

  assign cap      = bit_vld_i & ~drop_i;
  assign at_bnd_o = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      sr     <= '0;
      word_o <= '0;
      stb_o  <= 1'b0;
    end else begin
      stb_o <= 1'b0;
      if (cap) begin
        sr <= {sr[FACTOR-2:0], bit_i};
        if (cnt == CW'(FACTOR-1)) begin
          cnt    <= '0;
          word_o <= {sr[FACTOR-2:0], bit_i};
          stb_o  <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_DROP_HOLDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld_i && drop_i) |=> ($stable(cnt) && !stb_o)); // R3

endmodule

// File: rtl/bsa_slip_ctrl.sv
module bsa_slip_ctrl #(
  parameter int unsigned FACTOR = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic arst_i,
  input  logic bit_vld_i,
  input  logic at_bnd_i,
  input  logic word_stb_i,
  output logic drop_o,
  output logic roll_o
);
  localparam int unsigned SW = bsa_pkg::idx_w(FACTOR);
  localparam int unsigned KW = bsa_pkg::idx_w(FACTOR + 1);

  logic          req_q;
  logic [SW-1:0] slip_cnt;
  logic [KW-1:0] skip_cnt;
  logic [KW-1:0] undo;
  logic          busy;
  logic          roll_pend;
  logic          req_edge;
  logic          accept;
  logic          settle;
  logic          dec;
  logic          wrap;

  assign drop_o   = (skip_cnt != '0) & at_bnd_i;
  assign dec      = drop_o & bit_vld_i;
  assign req_edge = req_i & ~req_q;
  assign accept   = req_edge & ~busy & ~arst_i;
  assign settle   = busy & (skip_cnt == '0) & word_stb_i;
  assign roll_o   = settle & roll_pend;
  assign wrap     = (slip_cnt == SW'(FACTOR-1));

  always_comb begin
    if (slip_cnt == '0) undo = '0;
    else                undo = KW'(FACTOR) - KW'(slip_cnt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      slip_cnt  <= '0;
      skip_cnt  <= '0;
      busy      <= 1'b0;
      roll_pend <= 1'b0;
    end else begin
      req_q <= req_i;
      if (arst_i) begin
        slip_cnt  <= '0;
        skip_cnt  <= skip_cnt - KW'(dec) + undo;
        busy      <= (busy & ~settle) | (undo != '0);
        roll_pend <= 1'b0;
      end else if (accept) begin
        slip_cnt  <= wrap ? '0 : slip_cnt + 1'b1;
        skip_cnt  <= skip_cnt + 1'b1;
        busy      <= 1'b1;
        roll_pend <= wrap;
      end else begin
        skip_cnt <= skip_cnt - KW'(dec);
        if (settle) begin
          busy      <= 1'b0;
          roll_pend <= 1'b0;
        end
      end
    end
  end

  AST_ROLL_AT_ZERO_SLIP: assert property (@(posedge clk) disable iff (!rst_n)
    roll_o |-> (slip_cnt == '0)); // R5
  AST_ROLL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    roll_o |=> !roll_o); // R5
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_edge && !arst_i) |=> $stable(slip_cnt)); // R4
  AST_ARST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    arst_i |=> ((slip_cnt == '0) && !roll_o)); // R6
  AST_SKIP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    skip_cnt <= KW'(FACTOR)); // R6

endmodule

// File: rtl/bitslip_aligner.sv
module bitslip_aligner #(
  parameter int unsigned CHANNELS = 2,
  parameter int unsigned FACTOR   = 8,
  parameter int unsigned SHARED   = 0,
  localparam int unsigned NSLIP   = (SHARED != 0) ? 1 : CHANNELS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CHANNELS-1:0]        ser_i,
  input  logic                       ser_vld_i,
  input  logic [NSLIP-1:0]           slip_i,
  input  logic [CHANNELS-1:0]        align_rst_i,
  output logic [CHANNELS*FACTOR-1:0] word_o,
  output logic [CHANNELS-1:0]        word_vld_o,
  output logic [CHANNELS-1:0]        roll_o
);

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    localparam int unsigned SI = (SHARED != 0) ? 0 : c;
    logic drop;
    logic bnd;

    bsa_lane #(.FACTOR(FACTOR)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_i     (ser_i[c]),
      .bit_vld_i (ser_vld_i),
      .drop_i    (drop),
      .at_bnd_o  (bnd),
      .word_o    (word_o[c*FACTOR +: FACTOR]),
      .stb_o     (word_vld_o[c])
    );

    bsa_slip_ctrl #(.FACTOR(FACTOR)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (slip_i[SI]),
      .arst_i     (align_rst_i[c]),
      .bit_vld_i  (ser_vld_i),
      .at_bnd_i   (bnd),
      .word_stb_i (word_vld_o[c]),
      .drop_o     (drop),
      .roll_o     (roll_o[c])
    );

    AST_ROLL_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      roll_o[c] |-> word_vld_o[c]); // R5
  end

endmodule

// File: tb/bitslip_aligner_tb.sv
`timescale 1ns/1ps
module bitslip_aligner_tb;
  localparam int F = 8;
  localparam logic [F-1:0] W = 8'b1011_0100;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [1:0]    ser;
  logic          ser_vld;
  logic [1:0]    slip_a;
  logic [0:0]    slip_b;
  logic [1:0]    arst_a, arst_b;
  logic [2*F-1:0] wo_a, wo_b;
  logic [1:0]    wv_a, wv_b, ro_a, ro_b;

  bitslip_aligner #(.CHANNELS(2), .FACTOR(F), .SHARED(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .ser_i(ser), .ser_vld_i(ser_vld),
    .slip_i(slip_a), .align_rst_i(arst_a),
    .word_o(wo_a), .word_vld_o(wv_a), .roll_o(ro_a));

  bitslip_aligner #(.CHANNELS(2), .FACTOR(F), .SHARED(1)) u_dut_shared (
    .clk(clk), .rst_n(rst_n), .ser_i(ser), .ser_vld_i(ser_vld),
    .slip_i(slip_b), .align_rst_i(arst_b),
    .word_o(wo_b), .word_vld_o(wv_b), .roll_o(ro_b));

  int tests = 0;
  int fails = 0;
  int rc_a0 = 0, rc_a1 = 0, rc_b0 = 0, rc_b1 = 0;

  function automatic logic [F-1:0] rotl(input logic [F-1:0] w, input int n);
    int k = n % F;
    return (k == 0) ? w : ((w << k) | (w >> (F - k)));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // serial source: W repeated MSB first, enable low every third cycle (R2)
  initial begin
    int cyc = 0;
    int bidx = 0;
    ser = '0; ser_vld = 1'b0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      cyc++;
      ser_vld = (cyc % 3 != 2);
      if (ser_vld) begin
        ser = {2{W[F-1-(bidx % F)]}};
        bidx++;
      end else begin
        ser = 2'b00;
      end
    end
  end

  // roll-over monitors: count pulses, word at wrap must be unrotated (R5)
  always @(negedge clk) begin
    if (rst_n) begin
      if (ro_a[0]) begin rc_a0++; chk(wo_a[0+:F] == W, "R5 wrap word a0", wo_a[0+:F], W); end
      if (ro_a[1]) begin rc_a1++; chk(wo_a[F+:F] == W, "R5 wrap word a1", wo_a[F+:F], W); end
      if (ro_b[0]) begin rc_b0++; chk(wo_b[0+:F] == W, "R5 wrap word b0", wo_b[0+:F], W); end
      if (ro_b[1]) begin rc_b1++; chk(wo_b[F+:F] == W, "R5 wrap word b1", wo_b[F+:F], W); end
    end
  end

  task automatic word_a(input int c, input int n, output logic [F-1:0] w);
    for (int i = 0; i < n; i++) begin
      forever begin @(negedge clk); if (wv_a[c]) break; end
    end
    w = wo_a[c*F +: F];
  endtask

  task automatic word_b(input int c, input int n, output logic [F-1:0] w);
    for (int i = 0; i < n; i++) begin
      forever begin @(negedge clk); if (wv_b[c]) break; end
    end
    w = wo_b[c*F +: F];
  endtask

  task automatic pulse_slip_a(input int c);
    @(negedge clk); slip_a[c] = 1'b1;
    @(negedge clk); slip_a[c] = 1'b0;
  endtask

  task automatic pulse_arst_a(input int c);
    @(negedge clk); arst_a[c] = 1'b1;
    @(negedge clk); arst_a[c] = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    logic [F-1:0] w, w1;
    rst_n = 1'b0; slip_a = '0; slip_b = '0; arst_a = '0; arst_b = '0;
    repeat (4) @(negedge clk);
    // R8 reset state
    chk(wv_a == 0 && wv_b == 0, "R8 strobes", {wv_a, wv_b}, 0);
    chk(ro_a == 0 && ro_b == 0, "R8 roll", {ro_a, ro_b}, 0);
    chk(wo_a == 0 && wo_b == 0, "R8 words", {wo_a, wo_b}, 0);
    rst_n = 1'b1;

    // R1 / R2 first words with gapped enable
    word_a(0, 1, w); chk(w == W, "R1 first word a0", w, W);
    word_a(1, 1, w); chk(w == W, "R2 gapped word a1", w, W);
    word_a(0, 1, w); chk(w == W, "R2 steady word a0", w, W);

    // R3 / R5 sweep all slip counts on lane 0, R7 lane 1 untouched
    for (int k = 1; k <= F; k++) begin
      pulse_slip_a(0);
      word_a(0, 3, w);
      chk(w == rotl(W, k), "R3 rotation a0", w, rotl(W, k));
      chk(rc_a0 == ((k == F) ? 1 : 0), "R5 roll count a0", rc_a0, (k == F) ? 1 : 0);
      word_a(1, 1, w1);
      chk(w1 == W, "R7 independent a1", w1, W);
    end

    // R4 second edge during slip ignored, held level counts once
    pulse_slip_a(0);
    pulse_slip_a(0);
    word_a(0, 3, w);
    chk(w == rotl(W, 1), "R4 double edge", w, rotl(W, 1));
    @(negedge clk); slip_a[0] = 1'b1;
    repeat (60) @(negedge clk);
    slip_a[0] = 1'b0;
    word_a(0, 3, w);
    chk(w == rotl(W, 2), "R4 held level", w, rotl(W, 2));

    // R6 aligner reset from offset 2
    pulse_arst_a(0);
    word_a(0, 3, w);
    chk(w == W, "R6 reset offset a0", w, W);
    chk(rc_a0 == 1, "R6 no roll on reset", rc_a0, 1);

    // R6 reset while slip pending, lane 1 after three slips
    for (int k = 0; k < 3; k++) begin
      pulse_slip_a(1);
      word_a(1, 3, w);
    end
    chk(w == rotl(W, 3), "R3 rotation a1", w, rotl(W, 3));
    pulse_arst_a(1);
    word_a(1, 3, w);
    chk(w == W, "R6 reset offset a1", w, W);
    @(negedge clk); slip_a[0] = 1'b1;
    @(negedge clk); slip_a[0] = 1'b0; arst_a[0] = 1'b1;
    @(negedge clk); arst_a[0] = 1'b0;
    word_a(0, 3, w);
    chk(w == W, "R6 reset during slip", w, W);
    chk(rc_a0 == 1 && rc_a1 == 0, "R6 rolls unchanged", {rc_a0, rc_a1}, 1);

    // R7 shared control slips both lanes
    for (int k = 1; k <= F; k++) begin
      @(negedge clk); slip_b[0] = 1'b1;
      @(negedge clk); slip_b[0] = 1'b0;
      word_b(0, 3, w);
      w1 = wo_b[F +: F];
      chk(w == rotl(W, k), "R7 shared b0", w, rotl(W, k));
      chk(w1 == rotl(W, k) && wv_b[1], "R7 shared b1", w1, rotl(W, k));
    end
    chk(rc_b0 == 1 && rc_b1 == 1, "R5 shared rolls", {rc_b0, rc_b1}, 32'h0000_0000_1 | 1);

    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule